// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two levels of page tables from memory to do this. A requester hands over one address at a time through a valid/ready handshake. The walker also captures the physical page number of the root table from a configuration input at that moment.

The walker then reads the root-table entry chosen by the top ten bits of the virtual address. If that entry is valid, it reads the entry chosen by the next ten bits from the second table the first entry names. If that entry is valid too, the walker builds the physical address. Memory reads go out as one-cycle requests, and each answer comes back with a valid strobe after any number of cycles.

The result is a one-cycle response. It carries either the physical address, or a fault flag together with the level that failed.

Top module: `pt_walk`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `mem_req_o` and `rsp_valid_o` are 0.
- R2: The first read is issued in the cycle after acceptance, with `mem_req_o` high for exactly one cycle. Its address is `{root_ppn_i, 12'h000} + va[31:22]*4`, where `root_ppn_i` is sampled at acceptance.
- R3: The walker waits any number of cycles for `mem_rvalid_i`. It never has more than one read outstanding.
- R4: If bit 0 of the first entry is 1, a second read goes to `{pte1[31:12], 12'h000} + va[21:12]*4`.
- R5: If bit 0 of the second entry is 1, the response has `rsp_fault_o` = 0 and `rsp_pa_o = {pte2[31:12], va[11:0]}`.
- R6: If bit 0 of the first entry is 0, the response has `rsp_fault_o` = 1, `rsp_fault_lvl_o` = 0 and `rsp_pa_o` = 0. No second read is made.
- R7: If bit 0 of the second entry is 0, the response has `rsp_fault_o` = 1, `rsp_fault_lvl_o` = 1 and `rsp_pa_o` = 0.
- R8: `rsp_valid_o` is high for exactly one cycle. That cycle is the one right after the cycle in which the final `mem_rvalid_i` was seen.
- R9: `req_ready_o` is low from the cycle after acceptance through the response cycle, and is high again in the cycle after the response. While it is low, the request inputs and `root_ppn_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_va_i | input | 32 | Virtual address to translate |
| root_ppn_i | input | 20 | Physical page number of the root table |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Result valid, one cycle |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_fault_lvl_o | output | 1 | Faulting level: 0 first, 1 second |
| rsp_pa_o | output | 32 | Physical address, zero on fault |

## Verification
The result delivery and the arrival of the next request can fall in the same cycle. The bench keeps `req_valid_i` high for the whole walk. It does so with a scrambled address and a scrambled root, and keeps them there until the response cycle. A correct walker must ignore them and must not start a read in that cycle. The bench judges this by the addresses of the reads and by the translated result, both of which must match only the accepted request. A sweep over all 1024 first-level indices is run with memory latencies from one to four cycles. Memory contents come from an address hash, so both fault levels and clean translations occur.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD1,
    S_WT1,
    S_RD2,
    S_WT2,
    S_DONE
  } walk_state_e;
endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PTE_W = 32
) (
  input  logic [PA_W-OFF_W-1:0] tbl_ppn_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int unsigned SH = $clog2(PTE_W / 8);

  assign addr_o = {tbl_ppn_i, {OFF_W{1'b0}}} + (PA_W'(idx_i) << SH);
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_rvalid_i,
  input  logic pte_valid_i,
  output logic ready_o,
  output logic accept_o,
  output logic mem_req_o,
  output logic lvl2_o,
  output logic ld_next_o,
  output logic fin_ok_o,
  output logic fin_fault_o,
  output logic rsp_valid_o
);
  walk_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    accept_o    = 1'b0;
    mem_req_o   = 1'b0;
    lvl2_o      = 1'b0;
    ld_next_o   = 1'b0;
    fin_ok_o    = 1'b0;
    fin_fault_o = 1'b0;
    rsp_valid_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        ready_o = 1'b1;
        if (req_valid_i) begin
          accept_o = 1'b1;
          state_d  = S_RD1;
        end
      end
      S_RD1: begin
        mem_req_o = 1'b1;
        state_d   = S_WT1;
      end
      S_WT1: begin
        if (mem_rvalid_i) begin
          if (pte_valid_i) begin
            ld_next_o = 1'b1;
            state_d   = S_RD2;
          end else begin
            fin_fault_o = 1'b1;
            state_d     = S_DONE;
          end
        end
      end
      S_RD2: begin
        mem_req_o = 1'b1;
        lvl2_o    = 1'b1;
        state_d   = S_WT2;
      end
      S_WT2: begin
        lvl2_o = 1'b1;
        if (mem_rvalid_i) begin
          fin_ok_o    = pte_valid_i;
          fin_fault_o = !pte_valid_i;
          state_d     = S_DONE;
        end
      end
      S_DONE: begin
        rsp_valid_o = 1'b1;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pt_walk.sv
module pt_walk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PTE_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic [PA_W-OFF_W-1:0] root_ppn_i,
  output logic                 mem_req_o,
  output logic [PA_W-1:0]      mem_addr_o,
  input  logic                 mem_rvalid_i,
  input  logic [PTE_W-1:0]     mem_rdata_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_fault_o,
  output logic                 rsp_fault_lvl_o,
  output logic [PA_W-1:0]      rsp_pa_o
);
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned LEVELS = 2;

  logic             accept, lvl2, ld_next, fin_ok, fin_fault;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] tbl_ppn_q;
  logic [PA_W-1:0]  pa_q;
  logic             fault_q, lvl_q;
  logic [PPN_W-1:0] pte_ppn;
  logic [IDX_W-1:0] lvl_idx [LEVELS];
  logic [IDX_W-1:0] cur_idx;

  assign pte_ppn = mem_rdata_i[OFF_W +: PPN_W];

  // index slices, top level first
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = va_q[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign cur_idx = lvl2 ? lvl_idx[1] : lvl_idx[0];

  pt_walk_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mem_rvalid_i(mem_rvalid_i),
    .pte_valid_i (mem_rdata_i[0]),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .mem_req_o   (mem_req_o),
    .lvl2_o      (lvl2),
    .ld_next_o   (ld_next),
    .fin_ok_o    (fin_ok),
    .fin_fault_o (fin_fault),
    .rsp_valid_o (rsp_valid_o)
  );

  // one adder shared by both levels
  pt_walk_addr #(
    .PA_W (PA_W),
    .OFF_W(OFF_W),
    .IDX_W(IDX_W),
    .PTE_W(PTE_W)
  ) i_addr (
    .tbl_ppn_i(tbl_ppn_q),
    .idx_i    (cur_idx),
    .addr_o   (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q      <= '0;
      tbl_ppn_q <= '0;
      pa_q      <= '0;
      fault_q   <= 1'b0;
      lvl_q     <= 1'b0;
    end else begin
      if (accept) begin
        va_q      <= req_va_i;
        tbl_ppn_q <= root_ppn_i;
        pa_q      <= '0;
        fault_q   <= 1'b0;
        lvl_q     <= 1'b0;
      end
      if (ld_next) tbl_ppn_q <= pte_ppn;
      if (fin_ok)  pa_q <= {pte_ppn, va_q[OFF_W-1:0]};
      if (fin_fault) begin
        fault_q <= 1'b1;
        lvl_q   <= lvl2;
      end
    end
  end

  assign rsp_fault_o     = fault_q;
  assign rsp_fault_lvl_o = lvl_q;
  assign rsp_pa_o        = pa_q;
endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [PA_W-1:0] rsp_pa_o
);
  localparam int unsigned AL = $clog2(PTE_W / 8);

  logic [VA_W-1:0] own_va;
  logic            outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_va      <= '0;
      outstanding <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) own_va <= req_va_i;
      if (mem_req_o)         outstanding <= 1'b1;
      else if (mem_rvalid_i) outstanding <= 1'b0;
    end
  end

  a_r2_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r2_entry_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[AL-1:0] == '0));

  a_r3_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding |-> !mem_req_o);

  a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_pa_o[OFF_W-1:0] == own_va[OFF_W-1:0]));

  a_r6_fault_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0));

  a_r8_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r9_no_ready_in_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  a_r9_ready_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);
endmodule

bind pt_walk pt_walk_chk #(
  .VA_W (VA_W),
  .PA_W (PA_W),
  .OFF_W(OFF_W),
  .PTE_W(PTE_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_va_i    (req_va_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_pa_o    (rsp_pa_o)
);

// File: tb/test_pt_walk.sv
module test_pt_walk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [19:0] root_ppn = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_lvl;
  logic [31:0] rsp_pa;

  int total = 0, bad = 0, cyc = 0;
  int mem_busy = 0, mem_wait = 0, lat_sel = 0;
  logic [31:0] mem_at = '0;
  int rd_cnt = 0, rv_cyc = 0, overlap = 0;
  logic [31:0] rd_addr [2];
  int n_ok = 0, n_f1 = 0, n_f2 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pt_walk i_pt_walk (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_va_i       (req_va),
    .root_ppn_i     (root_ppn),
    .mem_req_o      (mem_req),
    .mem_addr_o     (mem_addr),
    .mem_rvalid_i   (mem_rvalid),
    .mem_rdata_i    (mem_rdata),
    .rsp_valid_o    (rsp_valid),
    .rsp_fault_o    (rsp_fault),
    .rsp_fault_lvl_o(rsp_lvl),
    .rsp_pa_o       (rsp_pa)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h, m;
    h = a * 32'h9E3779B1;
    m = h ^ (h >> 13);
    return {m[31:12], 11'h0, (h[27:24] != 4'h0)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: answers 1+lat_sel cycles after the request cycle
  initial begin
    rd_addr[0] = '0;
    rd_addr[1] = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_busy != 0) begin
        if (mem_wait == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(mem_at);
          mem_busy   = 0;
          rv_cyc     = cyc;
        end else mem_wait--;
      end
      if (mem_req === 1'b1) begin
        if (mem_busy != 0) overlap++;
        mem_busy = 1;
        mem_at   = mem_addr;
        mem_wait = lat_sel;
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] root, input int lat);
    logic [31:0] l1a, l2a, e1, e2, exp_pa;
    bit exp_f, exp_l;
    int exp_rd, n;
    l1a = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
    e1  = mem_word(l1a);
    l2a = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    e2  = mem_word(l2a);
    if (!e1[0]) begin
      exp_f = 1; exp_l = 0; exp_pa = '0; exp_rd = 1; n_f1++;
    end else if (!e2[0]) begin
      exp_f = 1; exp_l = 1; exp_pa = '0; exp_rd = 2; n_f2++;
    end else begin
      exp_f = 0; exp_l = 0; exp_pa = {e2[31:12], va[11:0]}; exp_rd = 2; n_ok++;
    end

    lat_sel = lat;
    @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_va    = va;
    root_ppn  = root;
    check(req_ready == 1'b1, "R9 ready before accept", 32'(req_ready), 32'd1);
    @(negedge clk);
    check(mem_req == 1'b1 && mem_addr == l1a, "R2 first read addr", mem_addr, l1a);
    // scrambled request held high while busy: must be ignored (R9)
    req_va   = ~va;
    root_ppn = ~root;
    n = 0;
    while (rsp_valid !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
      if (rsp_valid !== 1'b1 && req_ready !== 1'b0)
        check(1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
    end
    req_valid = 1'b0;
    if (n >= 60) begin
      check(1'b0, "R3 walk timeout", 32'(n), 32'd60);
    end else begin
      check(req_ready == 1'b0, "R9 ready low in rsp cycle", 32'(req_ready), 32'd0);
      check(cyc == rv_cyc + 1, "R8 rsp one cycle after rvalid", 32'(cyc), 32'(rv_cyc + 1));
      check(rd_cnt == exp_rd, exp_l || !exp_f ? "R4 read count" : "R6 read count", 32'(rd_cnt), 32'(exp_rd));
      if (exp_rd == 2)
        check(rd_addr[1] == l2a, "R4 second read addr", rd_addr[1], l2a);
      if (exp_f && !exp_l) begin
        check(rsp_fault == 1'b1 && rsp_lvl == 1'b0, "R6 level-1 fault", {30'h0, rsp_fault, rsp_lvl}, 32'h2);
        check(rsp_pa == '0, "R6 fault pa zero", rsp_pa, '0);
      end else if (exp_f) begin
        check(rsp_fault == 1'b1 && rsp_lvl == 1'b1, "R7 level-2 fault", {30'h0, rsp_fault, rsp_lvl}, 32'h3);
        check(rsp_pa == '0, "R7 fault pa zero", rsp_pa, '0);
      end else begin
        check(rsp_fault == 1'b0, "R5 no fault", 32'(rsp_fault), 32'd0);
        check(rsp_pa == exp_pa, "R5 physical address", rsp_pa, exp_pa);
      end
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 rsp pulse", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R9 ready after rsp", 32'(req_ready), 32'd1);
    check(mem_req == 1'b0, "R9 no read from held request", 32'(mem_req), 32'd0);
  endtask

  initial begin
    wait (cyc > 150000);
    check(1'b0, "R3 watchdog", 32'(cyc), 32'd150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R1 reset state",
          {29'h0, req_ready, mem_req, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready out of reset", 32'(req_ready), 32'd1);

    // corner addresses
    walk(32'h0000_0000, 20'h00000, 0);
    walk(32'hFFFF_FFFF, 20'hFFFFF, 3);
    walk(32'h7FC0_0ABC, 20'h12345, 1);

    // sweep every first-level index, latencies 1..4
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] va;
      logic [19:0] rt;
      va = {10'(i), 10'(i * 397 + 5), 12'(i * 2731)};
      rt = 20'(i * 40503 + 7);
      walk(va, rt, i % 4);
    end

    check(overlap == 0, "R3 single outstanding read", 32'(overlap), 32'd0);
    check(n_f1 > 0 && n_f2 > 0 && n_ok > 0, "R5 R6 R7 all outcomes seen",
          32'(n_f1 * 65536 + n_f2), 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule